// File: doc/BRIEF.md
# Dual-Range Pulse Width and Period Meter

This block times a single digital channel against a 125 ns sample strobe and reports either the length of the high phase or the interval between consecutive rising edges. A one-bit kind select picks between these two measurements. A one-bit scale select picks the timebase. On the fine scale every strobe counts. On the coarse scale one count is taken for every 128 strobes, so one count is 16 µs. The same 16-bit counter serves both scales. This gives a span of about 8.19 ms on the fine scale and about 1.05 s on the coarse scale.

The channel first passes through a synchronizer. It is then sampled only on strobe cycles, and edges are found by comparing each sample with the one before it. A two-state controller does the timing:
- **ST_WAIT** waits for a rising edge. The transition *arm* leads to ST_COUNT.
- **ST_COUNT** advances the counter on every timebase step.
  - *finish-width*: a falling edge in width kind returns to ST_WAIT.
  - *finish-period*: a rising edge in period kind stays in ST_COUNT and restarts at zero.
  - *saturate*: a step taken when the count is already all ones returns to ST_WAIT.
  - *abandon*: a change of kind or scale returns to ST_WAIT from either state.

Every finished or saturated measurement loads the result, pulses the valid strobe for one cycle and updates the overflow flag.

Top module: `pulse_meter`

## Requirements
- R1: After reset, `meas_value` is 0 and `meas_valid` and `meas_ovf` are low.
- R2: Period kind (`mode_width`=0) on the fine scale (`range_coarse`=0): a rising edge followed N strobes later by the next rising edge gives `meas_value`=N with `meas_ovf`=0.
- R3: Width kind (`mode_width`=1) on the fine scale: a rising edge followed N strobes later by a falling edge gives `meas_value`=N. The block then waits for the next rising edge.
- R4: On the coarse scale (`range_coarse`=1) the result is floor(N/128), where N is the number of strobes between the starting and ending edges. This holds in both kinds.
- R5: In period kind the rising edge that ends one measurement also starts the next, so every further rising edge yields a result.
- R6: When a timebase step arrives while the count is 65535, the block reports `meas_value`=65535 with `meas_ovf`=1 and `meas_valid` high. It then waits for a fresh rising edge. An interval of exactly 65535 counts is reported normally with `meas_ovf`=0.
- R7: `meas_ovf` changes only together with `meas_valid`. An in-range result clears it.
- R8: Any change of `mode_width` or `range_coarse` abandons the measurement in progress. No result follows in the next cycle, and the next rising edge is a fresh start that reports nothing by itself.
- R9: `meas_valid` is never high in two consecutive cycles.
- R10: In width kind, a falling edge that is not preceded by a rising edge seen in the current setting produces no result.
- R11: `meas_valid` rises only in the cycle after a cycle in which `tick_125` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sig_in | input | 1 | Channel under measurement, asynchronous |
| tick_125 | input | 1 | One-cycle strobe every 125 ns; sample and count enable |
| mode_width | input | 1 | 0 = period kind, 1 = high-width kind |
| range_coarse | input | 1 | 0 = fine scale (1 count per strobe), 1 = coarse scale (1 count per 128 strobes) |
| meas_value | output | 16 | Last measured count, saturated at 65535 |
| meas_valid | output | 1 | One-cycle strobe when `meas_value` is loaded |
| meas_ovf | output | 1 | Set when the last result saturated |

## Verification
The saturation boundary is driven on both sides: an interval of exactly 65535 counts must come back clean, and one longer than 65536 must come back flagged. A design that is off by one in the compare would flag the first or report a wrapped small count for the second. Coarse-scale widths of 127, 128 and 256 strobes target the prescaler phase. A prescaler not cleared at the starting edge, or a step missed at the ending tick, would report 1 instead of 0 or 1 instead of 2. Changes of kind and scale made in the middle of a measurement, including one made while the channel is high in width kind, expose a design that keeps counting across the change: it would emit a stale result or treat an orphan falling edge as an ending.

// File: rtl/pulse_meter_pkg.sv
package pulse_meter_pkg;

    // Controller states
    typedef enum logic {
        ST_WAIT  = 1'b0,   // idle, waiting for a starting rising edge
        ST_COUNT = 1'b1    // interval open, counting timebase steps
    } meter_state_e;

    // What is being timed
    typedef enum logic {
        KIND_PERIOD = 1'b0,   // rising edge to rising edge
        KIND_WIDTH  = 1'b1    // rising edge to falling edge
    } meas_kind_e;

    // Timebase selection
    typedef enum logic {
        SCALE_FINE   = 1'b0,  // one count per strobe
        SCALE_COARSE = 1'b1   // one count per prescaler wrap
    } meas_scale_e;

endpackage

// File: rtl/pulse_meter_sync.sv
module pulse_meter_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic d_sync
);

    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d_async;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[LAST-1:0], d_async};
            end
        end
    endgenerate

    assign d_sync = chain[LAST];

endmodule

// File: rtl/pulse_meter_edge.sv
module pulse_meter_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_en,
    input  logic level,
    output logic rise,
    output logic fall
);

    // Level captured at the previous sample strobe
    logic held;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         held <= 1'b0;
        else if (sample_en) held <= level;
    end

    assign rise = sample_en &  level & ~held;
    assign fall = sample_en & ~level &  held;

endmodule

// File: rtl/pulse_meter_timebase.sv
module pulse_meter_timebase #(
    parameter int DIV = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic coarse,
    input  logic clear,
    output logic step
);

    generate
        if (DIV > 1) begin : g_prescale
            localparam int PW = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);

            logic [PW-1:0] phase;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    phase <= '0;
                else if (clear)
                    phase <= '0;
                else if (tick && coarse)
                    phase <= (phase == LAST) ? '0 : phase + 1'b1;
            end

            // Coarse step on the strobe that completes DIV strobes
            assign step = coarse ? (tick && (phase == LAST)) : tick;
        end else begin : g_direct
            assign step = tick;
        end
    endgenerate

endmodule

// File: rtl/pulse_meter.sv
module pulse_meter
    import pulse_meter_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int COARSE_DIV  = 128,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_in,
    input  logic             tick_125,
    input  logic             mode_width,
    input  logic             range_coarse,
    output logic [CNT_W-1:0] meas_value,
    output logic             meas_valid,
    output logic             meas_ovf
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // ---------------- front end ----------------
    logic sig_s;
    logic edge_rise;
    logic edge_fall;

    pulse_meter_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (sig_in),
        .d_sync  (sig_s)
    );

    pulse_meter_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (tick_125),
        .level     (sig_s),
        .rise      (edge_rise),
        .fall      (edge_fall)
    );

    // ---------------- setting tracking ----------------
    meas_kind_e  kind_q;
    meas_scale_e scale_q;
    logic        setting_chg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q  <= KIND_PERIOD;
            scale_q <= SCALE_FINE;
        end else begin
            kind_q  <= meas_kind_e'(mode_width);
            scale_q <= meas_scale_e'(range_coarse);
        end
    end

    assign setting_chg = (meas_kind_e'(mode_width) != kind_q) ||
                         (meas_scale_e'(range_coarse) != scale_q);

    // ---------------- controller ----------------
    meter_state_e state;
    meter_state_e state_nx;

    logic             tb_step;
    logic             tb_clear;
    logic             end_edge;
    logic             sat_hit;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nx;

    assign end_edge = (kind_q == KIND_WIDTH) ? edge_fall : edge_rise;
    assign cnt_nx   = cnt + {{(CNT_W-1){1'b0}}, tb_step};
    assign sat_hit  = tb_step && (cnt == CNT_MAX);

    // Prescaler restarts whenever no interval is open or one closes
    assign tb_clear = setting_chg || (state == ST_WAIT) ||
                      ((state == ST_COUNT) && end_edge);

    pulse_meter_timebase #(.DIV(COARSE_DIV)) u_tb (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_125),
        .coarse (scale_q == SCALE_COARSE),
        .clear  (tb_clear),
        .step   (tb_step)
    );

    always_comb begin
        state_nx = state;
        if (setting_chg) begin
            state_nx = ST_WAIT;                       // abandon
        end else begin
            unique case (state)
                ST_WAIT: begin
                    if (edge_rise) state_nx = ST_COUNT;  // arm
                end
                ST_COUNT: begin
                    if (sat_hit)
                        state_nx = ST_WAIT;           // saturate
                    else if (end_edge && kind_q == KIND_WIDTH)
                        state_nx = ST_WAIT;           // finish-width
                    else
                        state_nx = ST_COUNT;          // finish-period or keep counting
                end
                default: state_nx = ST_WAIT;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_WAIT;
        else        state <= state_nx;
    end

    // Counter and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            meas_value <= '0;
            meas_valid <= 1'b0;
            meas_ovf   <= 1'b0;
        end else begin
            meas_valid <= 1'b0;
            if (setting_chg) begin
                cnt <= '0;
            end else begin
                unique case (state)
                    ST_WAIT: begin
                        cnt <= '0;
                    end
                    ST_COUNT: begin
                        if (sat_hit) begin
                            meas_value <= CNT_MAX;
                            meas_ovf   <= 1'b1;
                            meas_valid <= 1'b1;
                            cnt        <= '0;
                        end else if (end_edge) begin
                            meas_value <= cnt_nx;
                            meas_ovf   <= 1'b0;
                            meas_valid <= 1'b1;
                            cnt        <= '0;
                        end else begin
                            cnt <= cnt_nx;
                        end
                    end
                    default: cnt <= '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/pulse_meter_checks.sv
module pulse_meter_checks #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_125,
    input logic             mode_width,
    input logic             range_coarse,
    input logic [CNT_W-1:0] meas_value,
    input logic             meas_valid,
    input logic             meas_ovf
);

    AST_OVF_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_valid && meas_ovf) |-> (meas_value == {CNT_W{1'b1}})); // R6

    AST_OVF_MOVES_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(meas_ovf) |-> meas_valid); // R7

    AST_CHANGE_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_width != $past(mode_width)) || (range_coarse != $past(range_coarse)))
        |=> !meas_valid); // R8

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid |=> !meas_valid); // R9

    AST_VALID_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid |-> $past(tick_125)); // R11

endmodule

bind pulse_meter pulse_meter_checks #(.CNT_W(CNT_W)) u_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_125     (tick_125),
    .mode_width   (mode_width),
    .range_coarse (range_coarse),
    .meas_value   (meas_value),
    .meas_valid   (meas_valid),
    .meas_ovf     (meas_ovf)
);

// File: tb/sim_pulse_meter.sv
module sim_pulse_meter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sig = 1'b0;
    logic        tick = 1'b0;
    logic        mode_w = 1'b0;
    logic        rng = 1'b0;
    logic [15:0] val;
    logic        vld;
    logic        ovf;

    always #2 clk = ~clk;   // 250 MHz

    pulse_meter u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .sig_in       (sig),
        .tick_125     (tick),
        .mode_width   (mode_w),
        .range_coarse (rng),
        .meas_value   (val),
        .meas_valid   (vld),
        .meas_ovf     (ovf)
    );

    // Strobe generator: one high cycle every tick_div clocks
    int tick_div = 2;
    int tcnt = 0;
    always @(negedge clk) begin
        if (tcnt >= tick_div - 1) begin
            tcnt = 0;
            tick = 1'b1;
        end else begin
            tcnt = tcnt + 1;
            tick = 1'b0;
        end
    end

    typedef struct {
        logic        o;
        logic [15:0] v;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    exp_t got;
    int   n_chk = 0;
    int   n_bad = 0;
    logic prev_vld = 1'b0;
    logic tick_seen = 1'b0;
    bit   done = 1'b0;

    always @(posedge clk) tick_seen <= tick;

    task automatic chk(bit ok, string req, string what, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic expect_res(logic o, logic [15:0] v, string req);
        exp_t e;
        e.o = o;
        e.v = v;
        e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic wait_ticks(int n);
        for (int i = 0; i < n; i++) begin
            do @(posedge clk); while (tick !== 1'b1);
        end
    endtask

    task automatic pulse(int h, int l);
        #1 sig = 1'b1;
        wait_ticks(h);
        #1 sig = 1'b0;
        wait_ticks(l);
    endtask

    task automatic set_ctrl(logic m, logic r);
        #1 mode_w = m;
        rng = r;
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && vld) begin
            chk(!prev_vld, "R9", "valid in consecutive cycles", 1, 0);
            chk(tick_seen, "R11", "tick before valid", int'(tick_seen), 1);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8", "unexpected result", int'(val), -1);
            end else begin
                got = exp_q.pop_front();
                chk(val == got.v, got.req, "value", int'(val), int'(got.v));
                chk(ovf == got.o, got.req, "overflow", int'(ovf), int'(got.o));
            end
        end
        prev_vld = vld;
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(val == 16'd0, "R1", "reset value", int'(val), 0);
        chk(vld == 1'b0, "R1", "reset valid", int'(vld), 0);
        chk(ovf == 1'b0, "R1", "reset overflow", int'(ovf), 0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        wait_ticks(4);

        // R2 / R5: fine period, continuous
        expect_res(1'b0, 16'd8, "R2");
        expect_res(1'b0, 16'd10, "R5");
        expect_res(1'b0, 16'd12, "R5");
        expect_res(1'b0, 16'd2, "R2");
        pulse(3, 5); pulse(4, 6); pulse(10, 2); pulse(1, 1); pulse(2, 2);
        wait_ticks(2);

        // R3: fine width (the change also drops the open period, R8)
        set_ctrl(1'b1, 1'b0);
        wait_ticks(3);
        expect_res(1'b0, 16'd5, "R3");
        expect_res(1'b0, 16'd1, "R3");
        expect_res(1'b0, 16'd17, "R3");
        pulse(5, 3); pulse(1, 4); pulse(17, 3);

        // R10 / R8: switch to width while high, orphan falling edge ignored
        set_ctrl(1'b0, 1'b0);
        wait_ticks(3);
        #1 sig = 1'b1;
        wait_ticks(6);
        set_ctrl(1'b1, 1'b0);
        wait_ticks(5);
        #1 sig = 1'b0;
        wait_ticks(4);
        expect_res(1'b0, 16'd7, "R10");
        pulse(7, 3);

        // R8: scale toggled mid-period, next rising edge is a fresh start
        set_ctrl(1'b0, 1'b0);
        wait_ticks(3);
        pulse(4, 4);
        wait_ticks(3);
        set_ctrl(1'b0, 1'b1);
        wait_ticks(2);
        set_ctrl(1'b0, 1'b0);
        wait_ticks(2);
        expect_res(1'b0, 16'd12, "R8");
        pulse(6, 6); pulse(3, 3);
        wait_ticks(3);

        // R4: coarse scale, width then period
        tick_div = 1;
        set_ctrl(1'b1, 1'b1);
        wait_ticks(4);
        expect_res(1'b0, 16'd2, "R4");
        expect_res(1'b0, 16'd1, "R4");
        expect_res(1'b0, 16'd0, "R4");
        expect_res(1'b0, 16'd2, "R4");
        pulse(300, 5); pulse(128, 5); pulse(127, 5); pulse(256, 4);
        set_ctrl(1'b0, 1'b1);
        wait_ticks(4);
        expect_res(1'b0, 16'd2, "R4");
        expect_res(1'b0, 16'd0, "R4");
        pulse(100, 200); pulse(50, 50); pulse(1, 1);
        wait_ticks(3);

        // R6 / R7: fine period at the saturation boundary
        set_ctrl(1'b0, 1'b0);
        wait_ticks(4);
        expect_res(1'b0, 16'hFFFF, "R6");
        expect_res(1'b1, 16'hFFFF, "R6");
        expect_res(1'b0, 16'd7, "R7");
        pulse(10, 65525); pulse(10, 65590); pulse(3, 4); pulse(2, 2);
        wait_ticks(10);

        chk(exp_q.size() == 0, "R2", "results still pending", exp_q.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d pending expected 0", exp_q.size());
            summary();
            $finish;
        end
    end

endmodule